// File: doc/BRIEF.md
# Escaped Message Framer

This block sits between a byte-wide serial link and a message-level client. It carries management traffic to and from an external controller. Certain byte values are reserved on the link. `0xA0` closes a data message, `0xA1` closes a control message, and `0xAA` marks an escape: the byte after an escape has bit 4 (`0x10`) set, and clearing that bit gives back the real byte.

On the receive side the block removes escapes and collects the message content into a buffer of `MAX_LEN` bytes. When the closing byte arrives it validates the frame. A data message must hold at least four content bytes: a sequence byte, a function code, a command, optional data and a checksum. The checksum makes the 8-bit sum of all content bytes zero. A control message, such as a version report or a reset report, only needs one content byte. A valid frame is offered to the client through a random-access read port until the client acknowledges it. A bad frame is dropped, and a one-cycle error pulse with a code reports it.

On the transmit side the client streams content bytes with a last flag and a type flag. The block escapes every reserved value and appends the matching closing byte. It honours backpressure from the link.

Top module: `esc_msg_framer`

## Requirements
- R1: A received `0xAA` followed by a byte with bit 4 set yields one content byte equal to that byte with bit 4 cleared; neither link byte is otherwise stored.
- R2: `0xA0` closes a data message and `0xA1` closes a control message. On a valid frame `msg_valid` rises with `msg_ctrl` = 1 for control and 0 for data. `msg_len` is the number of content bytes, without the closing byte, and `msg_rd_data` returns content byte `msg_rd_addr`.
- R3: A data frame whose content bytes do not sum to zero modulo 256 is discarded with error code 3.
- R4: A data frame with fewer than 4 content bytes, or a control frame with none, is discarded with error code 3.
- R5: An escape followed by a byte whose bit 4 is clear is an escape fault. That byte is never taken as a closing byte, even when it is `0xA0` or `0xA1`. The frame is discarded with error code 1 when its closing byte arrives.
- R6: A frame of more than `MAX_LEN` content bytes is discarded with error code 2. A frame of exactly `MAX_LEN` bytes is accepted. When several faults meet in one frame, code 2 wins over code 1, and code 1 wins over code 3.
- R7: While `msg_valid` is high, the length, type and content stay unchanged and every received link byte is ignored. The first link byte after the cycle in which `msg_ack` is sampled starts a new frame.
- R8: `rx_err` is high for exactly the one cycle after the closing byte of a bad frame is sampled, and `msg_valid` rises in that same cycle for a good frame. The two never occur together.
- R9: On transmit, a content byte equal to `0xA0`, `0xA1` or `0xAA` goes out as `0xAA` followed by the byte with bit 4 set. Every other byte goes out unchanged.
- R10: After the content byte flagged `tx_last`, the block sends `0xA1` if `tx_ctrl` was set with that byte and `0xA0` if it was not.
- R11: While `link_tx_valid` is high and `link_tx_ready` is low, `link_tx_byte` holds its value.
- R12: After reset `msg_valid`, `rx_err` and `link_tx_valid` are low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_rx_valid | input | 1 | A link byte is present this cycle |
| link_rx_byte | input | 8 | Received link byte |
| msg_valid | output | 1 | A validated message is held for the client |
| msg_ctrl | output | 1 | Held message is a control message |
| msg_len | output | $clog2(MAX_LEN+1) | Content byte count of the held message |
| msg_rd_addr | input | $clog2(MAX_LEN) | Content byte index to read |
| msg_rd_data | output | 8 | Content byte at `msg_rd_addr` |
| msg_ack | input | 1 | Client releases the held message |
| rx_err | output | 1 | One-cycle pulse: a frame was discarded |
| rx_err_code | output | 2 | Fault class with `rx_err`: 1 escape, 2 overflow, 3 checksum or length |
| tx_valid | input | 1 | Client offers a content byte |
| tx_byte | input | 8 | Content byte to send |
| tx_last | input | 1 | This byte ends the message |
| tx_ctrl | input | 1 | With `tx_last`: close as a control message |
| tx_ready | output | 1 | Offered byte is taken this cycle |
| link_tx_valid | output | 1 | A link byte is offered |
| link_tx_byte | output | 8 | Link byte to send |
| link_tx_ready | input | 1 | Link accepts the byte this cycle |

## Verification
If the escape flag is stuck or stale, the first content byte after an escape shows up wrong at the read port. It can also cause a whole frame to be rejected with code 1. Either shows at the next closing byte. A wrong running count or sum surfaces as a wrong `msg_len` or a false code 3 in the cycle after that closing byte. A transmit phase error shows at once on the link as a missing escape, a byte without bit 4, or the wrong closing byte. The sweeps therefore pass every byte value through both directions, with the reserved values among them.

// File: rtl/efr_pkg.sv
package efr_pkg;

    localparam logic [7:0] SYM_END_DATA = 8'hA0;
    localparam logic [7:0] SYM_END_CTRL = 8'hA1;
    localparam logic [7:0] SYM_ESC      = 8'hAA;
    localparam logic [7:0] ESC_FLAG     = 8'h10;

    localparam int MIN_DATA_LEN = 4;
    localparam int MIN_CTRL_LEN = 1;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_ESCAPE    = 2'd1,
        ERR_OVERFLOW  = 2'd2,
        ERR_INTEGRITY = 2'd3
    } err_code_e;

    typedef enum logic [1:0] {
        TXP_EMPTY = 2'd0,
        TXP_ESC   = 2'd1,
        TXP_BYTE  = 2'd2,
        TXP_TERM  = 2'd3
    } tx_phase_e;

    function automatic logic is_reserved(input logic [7:0] b);
        return (b == SYM_END_DATA) || (b == SYM_END_CTRL) || (b == SYM_ESC);
    endfunction

endpackage

// File: rtl/efr_rx_unescape.sv
module efr_rx_unescape
    import efr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_bad_esc,
    output logic       out_term,
    output logic       out_term_ctrl
);

    typedef struct packed {
        logic esc_pend;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        out_valid     = 1'b0;
        out_byte      = in_byte;
        out_bad_esc   = 1'b0;
        out_term      = 1'b0;
        out_term_ctrl = 1'b0;
        if (flush) begin
            s_d.esc_pend = 1'b0;
        end else if (in_valid) begin
            if (s_q.esc_pend) begin
                // byte after an escape is always content, never a terminator
                s_d.esc_pend = 1'b0;
                if ((in_byte & ESC_FLAG) != 8'h00) begin
                    out_valid = 1'b1;
                    out_byte  = in_byte & ~ESC_FLAG;
                end else begin
                    out_bad_esc = 1'b1;
                end
            end else if (in_byte == SYM_ESC) begin
                s_d.esc_pend = 1'b1;
            end else if ((in_byte == SYM_END_DATA) || (in_byte == SYM_END_CTRL)) begin
                out_term      = 1'b1;
                out_term_ctrl = (in_byte == SYM_END_CTRL);
            end else begin
                out_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/efr_rx_assembler.sv
module efr_rx_assembler
    import efr_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int ADDR_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              bad_esc,
    input  logic              term,
    input  logic              term_ctrl,
    input  logic              msg_ack,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              msg_valid,
    output logic              msg_ctrl,
    output logic [LEN_W-1:0]  msg_len,
    output logic [7:0]        rd_data,
    output logic              err_pulse,
    output logic [1:0]        err_code
);

    localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_DMIN = LEN_W'(MIN_DATA_LEN);
    localparam logic [LEN_W-1:0] LEN_CMIN = LEN_W'(MIN_CTRL_LEN);

    typedef struct packed {
        logic [MAX_LEN-1:0][7:0] mem;
        logic [LEN_W-1:0]        cnt;
        logic [7:0]              sum;
        logic                    ovf;
        logic                    esc_bad;
        logic                    pend;
        logic                    ctrl;
        logic [LEN_W-1:0]        len;
        logic                    err;
        err_code_e               code;
    } state_t;

    state_t    s_d, s_q;
    logic      too_short;
    logic      sum_bad;
    err_code_e verdict;

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        s_d.code  = ERR_NONE;
        too_short = term_ctrl ? (s_q.cnt < LEN_CMIN) : (s_q.cnt < LEN_DMIN);
        sum_bad   = !term_ctrl && (s_q.sum != 8'h00);
        if (s_q.ovf)                  verdict = ERR_OVERFLOW;
        else if (s_q.esc_bad)         verdict = ERR_ESCAPE;
        else if (too_short || sum_bad) verdict = ERR_INTEGRITY;
        else                          verdict = ERR_NONE;

        if (s_q.pend) begin
            if (msg_ack) s_d.pend = 1'b0;
        end else begin
            if (byte_valid) begin
                if (s_q.cnt == LEN_MAX) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.mem[s_q.cnt[ADDR_W-1:0]] = byte_in;
                    s_d.cnt = s_q.cnt + LEN_W'(1);
                    s_d.sum = s_q.sum + byte_in;
                end
            end
            if (bad_esc) s_d.esc_bad = 1'b1;
            if (term) begin
                if (verdict == ERR_NONE) begin
                    s_d.pend = 1'b1;
                    s_d.ctrl = term_ctrl;
                    s_d.len  = s_q.cnt;
                end else begin
                    s_d.err  = 1'b1;
                    s_d.code = verdict;
                end
                s_d.cnt     = '0;
                s_d.sum     = 8'h00;
                s_d.ovf     = 1'b0;
                s_d.esc_bad = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if ((1 << ADDR_W) == MAX_LEN) begin : g_full_index
            assign rd_data = s_q.mem[rd_addr];
        end else begin : g_guarded_index
            assign rd_data = (rd_addr < ADDR_W'(MAX_LEN)) ? s_q.mem[rd_addr] : 8'h00;
        end
    endgenerate

    assign busy      = s_q.pend;
    assign msg_valid = s_q.pend;
    assign msg_ctrl  = s_q.ctrl;
    assign msg_len   = s_q.len;
    assign err_pulse = s_q.err;
    assign err_code  = s_q.code;

endmodule

// File: rtl/efr_tx_escaper.sv
module efr_tx_escaper
    import efr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    input  logic       in_ctrl,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    input  logic       out_ready
);

    typedef struct packed {
        tx_phase_e  phase;
        logic [7:0] cur;
        logic       last;
        logic       ctrl;
    } state_t;

    state_t s_d, s_q;
    logic   fire;
    logic   finishing;

    always_comb begin
        s_d       = s_q;
        out_valid = (s_q.phase != TXP_EMPTY);
        fire      = out_valid && out_ready;
        finishing = out_ready && ((s_q.phase == TXP_TERM) ||
                                  ((s_q.phase == TXP_BYTE) && !s_q.last));
        in_ready  = (s_q.phase == TXP_EMPTY) || finishing;

        case (s_q.phase)
            TXP_ESC:  out_byte = SYM_ESC;
            TXP_BYTE: out_byte = is_reserved(s_q.cur) ? (s_q.cur | ESC_FLAG) : s_q.cur;
            TXP_TERM: out_byte = s_q.ctrl ? SYM_END_CTRL : SYM_END_DATA;
            default:  out_byte = 8'h00;
        endcase

        if (fire) begin
            case (s_q.phase)
                TXP_ESC:  s_d.phase = TXP_BYTE;
                TXP_BYTE: s_d.phase = s_q.last ? TXP_TERM : TXP_EMPTY;
                default:  s_d.phase = TXP_EMPTY;
            endcase
        end

        if (in_valid && in_ready) begin
            s_d.cur   = in_byte;
            s_d.last  = in_last;
            s_d.ctrl  = in_ctrl;
            s_d.phase = is_reserved(in_byte) ? TXP_ESC : TXP_BYTE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/esc_msg_framer.sv
module esc_msg_framer
    import efr_pkg::*;
#(
    parameter int MAX_LEN = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_rx_valid,
    input  logic [7:0]        link_rx_byte,
    output logic              msg_valid,
    output logic              msg_ctrl,
    output logic [LEN_W-1:0]  msg_len,
    input  logic [ADDR_W-1:0] msg_rd_addr,
    output logic [7:0]        msg_rd_data,
    input  logic              msg_ack,
    output logic              rx_err,
    output logic [1:0]        rx_err_code,
    input  logic              tx_valid,
    input  logic [7:0]        tx_byte,
    input  logic              tx_last,
    input  logic              tx_ctrl,
    output logic              tx_ready,
    output logic              link_tx_valid,
    output logic [7:0]        link_tx_byte,
    input  logic              link_tx_ready
);

    logic       rx_busy;
    logic       un_valid;
    logic [7:0] un_byte;
    logic       un_bad_esc;
    logic       un_term;
    logic       un_term_ctrl;

    efr_rx_unescape u_unescape (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (rx_busy),
        .in_valid      (link_rx_valid),
        .in_byte       (link_rx_byte),
        .out_valid     (un_valid),
        .out_byte      (un_byte),
        .out_bad_esc   (un_bad_esc),
        .out_term      (un_term),
        .out_term_ctrl (un_term_ctrl)
    );

    efr_rx_assembler #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .ADDR_W  (ADDR_W)
    ) u_assembler (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (un_valid),
        .byte_in    (un_byte),
        .bad_esc    (un_bad_esc),
        .term       (un_term),
        .term_ctrl  (un_term_ctrl),
        .msg_ack    (msg_ack),
        .rd_addr    (msg_rd_addr),
        .busy       (rx_busy),
        .msg_valid  (msg_valid),
        .msg_ctrl   (msg_ctrl),
        .msg_len    (msg_len),
        .rd_data    (msg_rd_data),
        .err_pulse  (rx_err),
        .err_code   (rx_err_code)
    );

    efr_tx_escaper u_escaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_byte   (tx_byte),
        .in_last   (tx_last),
        .in_ctrl   (tx_ctrl),
        .in_ready  (tx_ready),
        .out_valid (link_tx_valid),
        .out_byte  (link_tx_byte),
        .out_ready (link_tx_ready)
    );

endmodule

// File: rtl/efr_checker.sv
module efr_checker #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ctrl,
    input logic [LEN_W-1:0] msg_len,
    input logic             msg_ack,
    input logic             rx_err,
    input logic             link_tx_valid,
    input logic [7:0]       link_tx_byte,
    input logic             link_tx_ready
);

    assert_held_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_len) && $stable(msg_ctrl)));

    assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_len <= LEN_W'(MAX_LEN)));

    assert_data_min_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ctrl) |-> (msg_len >= LEN_W'(4)));

    assert_err_excludes_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> !$rose(msg_valid));

    assert_escape_followed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_tx_valid && link_tx_ready && (link_tx_byte == 8'hAA))
            |=> (link_tx_valid && link_tx_byte[4]));

    assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (link_tx_valid && !link_tx_ready) |=> (link_tx_valid && $stable(link_tx_byte)));

endmodule

bind esc_msg_framer efr_checker #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
) u_efr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .msg_valid     (msg_valid),
    .msg_ctrl      (msg_ctrl),
    .msg_len       (msg_len),
    .msg_ack       (msg_ack),
    .rx_err        (rx_err),
    .link_tx_valid (link_tx_valid),
    .link_tx_byte  (link_tx_byte),
    .link_tx_ready (link_tx_ready)
);

// File: tb/test_esc_msg_framer.sv
module test_esc_msg_framer;

    localparam int CLK_PERIOD = 10;
    localparam int MAXL       = 8;
    localparam int LW         = $clog2(MAXL + 1);
    localparam int AW         = $clog2(MAXL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_rx_valid = 1'b0;
    logic [7:0]    link_rx_byte = 8'h00;
    logic          msg_valid;
    logic          msg_ctrl;
    logic [LW-1:0] msg_len;
    logic [AW-1:0] msg_rd_addr = '0;
    logic [7:0]    msg_rd_data;
    logic          msg_ack = 1'b0;
    logic          rx_err;
    logic [1:0]    rx_err_code;
    logic          tx_valid = 1'b0;
    logic [7:0]    tx_byte = 8'h00;
    logic          tx_last = 1'b0;
    logic          tx_ctrl = 1'b0;
    logic          tx_ready;
    logic          link_tx_valid;
    logic [7:0]    link_tx_byte;
    logic          link_tx_ready;

    esc_msg_framer #(.MAX_LEN(MAXL)) i_esc_msg_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_rx_valid (link_rx_valid),
        .link_rx_byte  (link_rx_byte),
        .msg_valid     (msg_valid),
        .msg_ctrl      (msg_ctrl),
        .msg_len       (msg_len),
        .msg_rd_addr   (msg_rd_addr),
        .msg_rd_data   (msg_rd_data),
        .msg_ack       (msg_ack),
        .rx_err        (rx_err),
        .rx_err_code   (rx_err_code),
        .tx_valid      (tx_valid),
        .tx_byte       (tx_byte),
        .tx_last       (tx_last),
        .tx_ctrl       (tx_ctrl),
        .tx_ready      (tx_ready),
        .link_tx_valid (link_tx_valid),
        .link_tx_byte  (link_tx_byte),
        .link_tx_ready (link_tx_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // link transmit capture with optional stalls
    logic [7:0] cap [0:63];
    int         cap_n = 0;
    bit         stall_en = 1'b0;
    int         cyc = 0;

    always @(negedge clk) begin
        cyc++;
        link_tx_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
        if (rst_n && link_tx_valid && link_tx_ready && cap_n < 64) begin
            cap[cap_n] = link_tx_byte;
            cap_n++;
        end
    end

    // receive-side helpers
    logic [7:0] fr [0:15];
    int         fr_len;

    function automatic bit resv(input logic [7:0] b);
        return (b == 8'hA0) || (b == 8'hA1) || (b == 8'hAA);
    endfunction

    function automatic logic [7:0] neg_sum(input int n);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < n; i++) s = s + fr[i];
        return 8'h00 - s;
    endfunction

    task automatic link_put(input logic [7:0] b);
        @(negedge clk);
        link_rx_valid = 1'b1;
        link_rx_byte  = b;
    endtask

    task automatic link_idle();
        @(negedge clk);
        link_rx_valid = 1'b0;
    endtask

    task automatic send_body();
        for (int i = 0; i < fr_len; i++) begin
            if (resv(fr[i])) begin
                link_put(8'hAA);
                link_put(fr[i] | 8'h10);
            end else begin
                link_put(fr[i]);
            end
        end
    endtask

    task automatic send_frame(input bit ctrl);
        send_body();
        link_put(ctrl ? 8'hA1 : 8'hA0);
        link_idle();
    endtask

    task automatic check_msg(input string req, input bit ctrl);
        check_eq(req, "msg_valid", int'(msg_valid), 1);
        check_eq(req, "rx_err", int'(rx_err), 0);
        check_eq(req, "msg_len", int'(msg_len), fr_len);
        check_eq(req, "msg_ctrl", int'(msg_ctrl), int'(ctrl));
        for (int i = 0; i < fr_len; i++) begin
            msg_rd_addr = AW'(i);
            #1;
            check_eq(req, "content byte", int'(msg_rd_data), int'(fr[i]));
        end
    endtask

    task automatic check_err(input string req, input int code);
        check_eq(req, "rx_err", int'(rx_err), 1);
        check_eq(req, "rx_err_code", int'(rx_err_code), code);
        check_eq(req, "msg_valid", int'(msg_valid), 0);
        link_idle();
        check_eq("R8", "rx_err one cycle", int'(rx_err), 0);
    endtask

    task automatic do_ack();
        @(negedge clk);
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
        check_eq("R7", "released after ack", int'(msg_valid), 0);
    endtask

    // transmit-side helpers
    logic [7:0] exp_b [0:63];
    int         exp_n;

    task automatic tx_put(input logic [7:0] b, input bit last, input bit ctrl);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_byte  = b;
        tx_last  = last;
        tx_ctrl  = ctrl;
        #1;
        while (!tx_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic tx_expect(input logic [7:0] b, input bit last, input bit ctrl);
        if (resv(b)) begin
            exp_b[exp_n] = 8'hAA;
            exp_b[exp_n + 1] = b | 8'h10;
            exp_n += 2;
        end else begin
            exp_b[exp_n] = b;
            exp_n++;
        end
        if (last) begin
            exp_b[exp_n] = ctrl ? 8'hA1 : 8'hA0;
            exp_n++;
        end
    endtask

    task automatic tx_compare(input string req);
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (12) @(negedge clk);
        check_eq(req, "link byte count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            check_eq(req, "link byte", int'(cap[i]), int'(exp_b[i]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check_eq("R12", "msg_valid in reset", int'(msg_valid), 0);
        check_eq("R12", "rx_err in reset", int'(rx_err), 0);
        check_eq("R12", "link_tx_valid in reset", int'(link_tx_valid), 0);
        check_eq("R12", "tx_ready in reset", int'(tx_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3: sweep every byte value through a valid data frame
        for (int v = 0; v < 256; v++) begin
            fr[0] = 8'(v);
            fr[1] = 8'hA0;
            fr[2] = ~8'(v);
            fr[3] = 8'(v + 1);
            fr_len = 4;
            fr[4] = neg_sum(4);
            fr_len = 5;
            send_frame(1'b0);
            check_msg("R1", 1'b0);
            do_ack();
        end

        // R2 control messages: version report and reset report
        fr[0] = 8'hFF; fr[1] = 8'h01; fr_len = 2;
        send_frame(1'b1);
        check_msg("R2", 1'b1);
        do_ack();
        fr[0] = 8'h04; fr_len = 1;
        send_frame(1'b1);
        check_msg("R2", 1'b1);
        do_ack();

        // R3 bad checksum
        fr[0] = 8'h01; fr[1] = 8'h02; fr[2] = 8'h03; fr[3] = 8'h04; fr_len = 4;
        send_frame(1'b0);
        check_err("R3", 3);

        // R4 short data frame with zero sum, then empty control frame
        fr[0] = 8'h00; fr[1] = 8'h00; fr[2] = 8'h00; fr_len = 3;
        send_frame(1'b0);
        check_err("R4", 3);
        fr_len = 0;
        send_frame(1'b1);
        check_err("R4", 3);

        // R5 escape then a raw terminator value is not a terminator
        link_put(8'hAA);
        link_put(8'hA0);
        link_idle();
        check_eq("R5", "no frame end on escaped A0", int'(msg_valid | rx_err), 0);
        fr[0] = 8'h00; fr[1] = 8'h00; fr[2] = 8'h00; fr[3] = 8'h00; fr_len = 4;
        send_frame(1'b0);
        check_err("R5", 1);
        // R5 escape fault wins over checksum fault
        link_put(8'hAA);
        link_put(8'h05);
        fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33; fr[3] = 8'h44; fr_len = 4;
        send_frame(1'b0);
        check_err("R5", 1);

        // R6 exactly MAXL bytes accepted
        for (int i = 0; i < MAXL - 1; i++) fr[i] = 8'(8'h30 + i);
        fr_len = MAXL - 1;
        fr[MAXL - 1] = neg_sum(MAXL - 1);
        fr_len = MAXL;
        send_frame(1'b0);
        check_msg("R6", 1'b0);
        do_ack();
        // R6 one byte too many, with an escape fault as well: overflow wins
        for (int i = 0; i < MAXL + 1; i++) fr[i] = 8'h00;
        fr_len = MAXL + 1;
        link_put(8'hAA);
        link_put(8'h01);
        send_frame(1'b0);
        check_err("R6", 2);

        // R7 held message ignores a whole new frame until acknowledged
        fr[0] = 8'h05; fr[1] = 8'h18; fr[2] = 8'h01; fr_len = 3;
        fr[3] = neg_sum(3); fr_len = 4;
        send_frame(1'b0);
        check_msg("R7", 1'b0);
        link_put(8'h77);
        link_put(8'hA1);
        link_put(8'h01);
        link_put(8'h02);
        link_put(8'hA0);
        link_idle();
        link_idle();
        check_msg("R7", 1'b0);
        do_ack();
        fr[0] = 8'h04; fr_len = 1;
        send_frame(1'b1);
        check_msg("R7", 1'b1);
        do_ack();

        // R9 R10: sweep every byte value as a one-byte message
        for (int v = 0; v < 256; v++) begin
            cap_n = 0;
            exp_n = 0;
            tx_put(8'(v), 1'b1, v[0]);
            tx_expect(8'(v), 1'b1, v[0]);
            tx_compare(v[0] ? "R10" : "R9");
        end

        // R11 multi-byte message with reserved bytes under link stalls
        stall_en = 1'b1;
        cap_n = 0;
        exp_n = 0;
        tx_put(8'hA0, 1'b0, 1'b0); tx_expect(8'hA0, 1'b0, 1'b0);
        tx_put(8'h11, 1'b0, 1'b0); tx_expect(8'h11, 1'b0, 1'b0);
        tx_put(8'hAA, 1'b0, 1'b0); tx_expect(8'hAA, 1'b0, 1'b0);
        tx_put(8'hA1, 1'b1, 1'b0); tx_expect(8'hA1, 1'b1, 1'b0);
        tx_compare("R11");
        // R10 control close under stalls
        cap_n = 0;
        exp_n = 0;
        tx_put(8'hFF, 1'b0, 1'b0); tx_expect(8'hFF, 1'b0, 1'b0);
        tx_put(8'h01, 1'b1, 1'b1); tx_expect(8'h01, 1'b1, 1'b1);
        tx_compare("R10");
        stall_en = 1'b0;

        report();
    end

endmodule